// File: doc/BRIEF.md
# Multi-Converter Select-Line Read Sequencer

This block is the host side of a serial link to several 16-bit converters that share one convert strobe, one serial clock and one data line, each with its own active-low select. A start request raises the convert strobe for all converters together, with every select held high so that each converter enters its select-driven readout mode without a busy flag. The block then waits a programmed number of system clocks that covers the longest conversion time.

After the wait, the converters are read one at a time in index order. The block lowers one select, which puts that converter's most significant bit on the data line. It then issues 16 serial clock pulses, capturing one bit per pulse with the MSB first. It raises the select together with the 16th falling edge, and holds all selects high for at least one clock before the next converter is selected. Each finished word leaves on a parallel output with the converter index and a one-cycle valid strobe. The convert strobe stays high until the last converter has been read. It falls in the same cycle as a one-cycle done pulse.

Parameters set the number of converters, the word width, the conversion wait, the serial-clock half period and the capture edge. With rising capture, each bit is sampled on a rising edge. With falling capture, each bit is sampled at the falling edge that replaces it, relying on the converter's output hold time.

Top module: `adc_cs_sequencer`

## Requirements
- R1: While `cnv_o` is rising, all bits of `sel_n_o` are 1. They stay 1 for exactly CONV_CYC clocks, counted from the clock in which `cnv_o` goes high, before select 0 is lowered.
- R2: `cnv_o` is 0 after reset and while idle. Once raised, it stays 1 until all N_DEV results have been delivered, and it falls only in the cycle in which `done_o` is 1.
- R3: Converters are read in index order 0, 1, … N_DEV-1. Select bit k (active low, bit k of `sel_n_o`) belongs to converter k, and at most one select bit is 0 at a time.
- R4: `sck_o` is 0 while no converter is selected. Each read issues exactly 16 pulses. Every low and every high phase lasts CLK_DIV clocks, including the low phase from the lowering of the select to the first rising edge.
- R5: With CAPTURE_FALL=0, bits are sampled on the rising edges of `sck_o`. The first rising edge gives bit 15 (MSB), and the result equals the word the converter held.
- R6: With CAPTURE_FALL=1, bits are sampled at each falling edge from the value present just before that edge, MSB first. The result equals the word the converter held.
- R7: A select rises in the same clock as the 16th falling edge. All selects then stay high for at least one clock before the next select is lowered, and a low select never moves directly to another converter.
- R8: Each read produces a one-cycle `res_valid_o` with `res_data_o` and `res_idx_o`. `res_idx_o` is the converter index, and the strobe appears in the clock in which the select rises.
- R9: `start_i` has no effect while a sequence is running (from the rise of `cnv_o` to `done_o`). It is not stored, and the sequence still delivers exactly N_DEV results in order.
- R10: `done_o` is a one-cycle pulse in the first clock with `cnv_o` low. A `start_i` seen in that clock raises `cnv_o` again in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion and read sequence when idle |
| cnv_o | output | 1 | Shared convert strobe |
| sck_o | output | 1 | Shared serial clock, parked low |
| sel_n_o | output | N_DEV | Per-converter select, active low |
| sdo_i | input | 1 | Shared serial data from the converters |
| res_data_o | output | DATA_W | Captured result word |
| res_idx_o | output | IDX_W | Index of the converter the word came from |
| res_valid_o | output | 1 | One-cycle strobe for the result outputs |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Two events can fall in the same clock: the end of a sequence (`cnv_o` falling together with `done_o`) and the acceptance of a new start. The bench raises `start_i` in the very clock in which `done_o` is seen. It then expects `cnv_o` to be high one clock later, after exactly one low clock, and expects the second sequence to deliver a full, ordered set of results. The 16th falling edge, the raising of the select and, with falling capture, the capture of the last bit also share one clock. A converter model drives the data line from the select and clock edges. The bench judges this coincidence through the result word and through the rule that the select rises with the 16th falling edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CONV,
    SQ_SHIFT,
    SQ_GAP
  } seq_state_t;
endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] half_cnt;
  logic          tick;

  assign tick   = run_i && (half_cnt == '0);
  assign rise_o = tick && !sck_o;
  assign fall_o = tick && sck_o;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      sck_o    <= 1'b0;
      half_cnt <= HW'(HALF - 1);
    end else if (tick) begin
      sck_o    <= ~sck_o;
      half_cnt <= HW'(HALF - 1);
    end else begin
      half_cnt <= half_cnt - 1'b1;
    end
  end

  AST_SCK_PARKS_LOW: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !sck_o); // R4
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)       word_o <= '0;
    else if (en_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/adc_cs_sequencer.sv
module adc_cs_sequencer
  import adc_seq_pkg::*;
#(
  parameter int N_DEV        = 3,
  parameter int DATA_W       = 16,
  parameter int CONV_CYC     = 10,
  parameter int CLK_DIV      = 2,
  parameter bit CAPTURE_FALL = 1'b0,
  parameter int IDX_W        = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              cnv_o,
  output logic              sck_o,
  output logic [N_DEV-1:0]  sel_n_o,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic              res_valid_o,
  output logic              done_o
);
  localparam int CW    = $clog2(CONV_CYC + 1);
  localparam int FCW   = $clog2(DATA_W + 1);
  localparam int LAST  = N_DEV - 1;

  seq_state_t        state;
  logic [CW-1:0]     conv_cnt;
  logic [FCW-1:0]    fall_cnt;
  logic [IDX_W-1:0]  dev;
  logic [IDX_W-1:0]  dev_nxt;
  logic              rise_now, fall_now, cap_en;
  logic [DATA_W-1:0] cap_word, final_word;

  assign dev_nxt = dev + 1'b1;

  adc_sck_gen #(.HALF(CLK_DIV)) u_sck (
    .clk(clk), .rst(rst), .run_i(state == SQ_SHIFT),
    .sck_o(sck_o), .rise_o(rise_now), .fall_o(fall_now)
  );

  generate
    if (CAPTURE_FALL) begin : g_fall
      assign cap_en     = fall_now;
      assign final_word = {cap_word[DATA_W-2:0], sdo_i};
    end else begin : g_rise
      assign cap_en     = rise_now;
      assign final_word = cap_word;
    end
  endgenerate

  adc_shift_in #(.W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .en_i(cap_en), .bit_i(sdo_i), .word_o(cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      cnv_o       <= 1'b0;
      sel_n_o     <= '1;
      conv_cnt    <= '0;
      fall_cnt    <= '0;
      dev         <= '0;
      res_data_o  <= '0;
      res_idx_o   <= '0;
      res_valid_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      done_o      <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start_i) begin
            cnv_o    <= 1'b1;
            conv_cnt <= CW'(CONV_CYC - 1);
            dev      <= '0;
            state    <= SQ_CONV;
          end
        end
        SQ_CONV: begin
          if (conv_cnt == '0) begin
            sel_n_o  <= ~(N_DEV'(1));
            fall_cnt <= '0;
            state    <= SQ_SHIFT;
          end else begin
            conv_cnt <= conv_cnt - 1'b1;
          end
        end
        SQ_SHIFT: begin
          if (fall_now) begin
            fall_cnt <= fall_cnt + 1'b1;
            if (fall_cnt == FCW'(DATA_W - 1)) begin
              sel_n_o     <= '1;
              res_data_o  <= final_word;
              res_idx_o   <= dev;
              res_valid_o <= 1'b1;
              state       <= SQ_GAP;
            end
          end
        end
        SQ_GAP: begin
          if (dev == IDX_W'(LAST)) begin
            cnv_o  <= 1'b0;
            done_o <= 1'b1;
            state  <= SQ_IDLE;
          end else begin
            dev      <= dev_nxt;
            sel_n_o  <= ~(N_DEV'(1) << dev_nxt);
            fall_cnt <= '0;
            state    <= SQ_SHIFT;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_CNV_ALL_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> (&sel_n_o)); // R1
  AST_SELECT_UNDER_CNV: assert property (@(posedge clk) disable iff (rst)
    !(&sel_n_o) |-> cnv_o); // R2
  AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n_o)); // R3
  AST_SCK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> !(&sel_n_o)); // R4
  AST_NO_DIRECT_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (!(&sel_n_o) && !(&$past(sel_n_o))) |-> (sel_n_o == $past(sel_n_o))); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |=> !res_valid_o); // R8
  AST_VALID_INDEX: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (res_idx_o <= IDX_W'(LAST))); // R8
  AST_DONE_CNV_LOW: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!cnv_o && $past(cnv_o))); // R10
endmodule

// File: tb/sim_adc_cs_sequencer.sv
module seq_watch #(
  parameter int N    = 3,
  parameter int DIV  = 2,
  parameter int CONV = 10,
  parameter bit FALL = 1'b0,
  parameter int IW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N*16-1:0] words,
  input  logic          cnv,
  input  logic          sck,
  input  logic [N-1:0]  sel_n,
  input  logic [15:0]   rdata,
  input  logic [IW-1:0] ridx,
  input  logic          rvalid,
  input  logic          done,
  output logic          sdo
);
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (capture_fall=%0d) %s: actual %0h expected %0h",
               req, FALL, what, act, exp);
    end
  endtask

  // converter model: drives after each clock edge, holding the old bit across it
  int act_dev = 0;
  int bitn = 0;
  bit drv = 0;
  logic [N-1:0] msel_q = '1;
  logic msck_q = 1'b0;
  initial sdo = 1'b0;
  always @(posedge clk) begin
    #1;
    if (msck_q && !sck && drv) begin
      bitn++;
      if (bitn == 16) drv = 0;
    end
    for (int k = 0; k < N; k++) begin
      if (msel_q[k] && !sel_n[k]) begin act_dev = k; bitn = 0; drv = 1; end
      if (!msel_q[k] && sel_n[k] && act_dev == k) drv = 0;
    end
    sdo = drv ? words[act_dev*16 + 15 - bitn] : 1'b0;
    msel_q = sel_n;
    msck_q = sck;
  end

  // protocol and result monitor
  bit cnv_q = 0, any_q = 0, sck_q = 0;
  int conv_run = 0, exp_dev = 0, pulses = 0, run = 0, gap_run = 0, res_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      automatic bit any = !(&sel_n);
      automatic int k = 0;
      for (int j = 0; j < N; j++) if (!sel_n[j]) k = j;
      if (cnv && !cnv_q) begin
        chk(&sel_n, "R1", "selects while convert rises", sel_n, {N{1'b1}});
        conv_run = 0; exp_dev = 0; res_cnt = 0;
      end
      if (cnv && !any && exp_dev == 0) conv_run++;
      if (any && !any_q) begin
        chk($countones(~sel_n) == 1, "R3", "selects low at once", $countones(~sel_n), 1);
        chk(k == exp_dev, "R3", "converter order", k, exp_dev);
        if (exp_dev == 0) chk(conv_run == CONV, "R1", "conversion wait clocks", conv_run, CONV);
        else chk(gap_run >= 1, "R7", "idle clocks between reads", gap_run, 1);
        pulses = 0; run = 0;
      end
      if (any) begin
        if (sck != sck_q) begin
          chk(run == DIV, "R4", sck ? "low phase length" : "high phase length", run, DIV);
          if (sck) pulses++;
          run = 1;
        end else run++;
      end
      if (!any && any_q) begin
        chk(pulses == 16, "R4", "pulses per read", pulses, 16);
        chk(sck_q && !sck, "R7", "select rise with 16th falling edge", {sck_q, sck}, 2'b10);
        chk(run == DIV, "R4", "last high phase length", run, DIV);
        gap_run = 0; exp_dev++;
      end
      if (!any && cnv && exp_dev > 0) gap_run++;
      if (!any) chk(!sck, "R4", "clock parked low", sck, 0);
      if (rvalid) begin
        chk(int'(ridx) == res_cnt, "R8", "result index", ridx, res_cnt);
        chk(rdata == words[int'(ridx)*16 +: 16], FALL ? "R6" : "R5", "result word",
            rdata, words[int'(ridx)*16 +: 16]);
        chk(!any, "R8", "valid in select-rise clock", any, 0);
        res_cnt++;
      end
      if (done) begin
        chk(!cnv, "R10", "convert low with done", cnv, 0);
        chk(res_cnt == N, "R2", "results before convert fell", res_cnt, N);
      end
      if (!cnv && cnv_q) chk(done, "R2", "convert falls only with done", done, 1);
      any_q = any; sck_q = sck; cnv_q = cnv;
    end
  end
endmodule

module sim_adc_cs_sequencer;
  localparam int N  = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic start0 = 1'b0, start1 = 1'b0;
  logic [N*16-1:0] words = '0;
  logic cnv0, sck0, sdo0, val0, done0, cnv1, sck1, sdo1, val1, done1;
  logic [N-1:0] sel0, sel1;
  logic [15:0] dat0, dat1;
  logic [IW-1:0] idx0, idx1;

  adc_cs_sequencer #(.N_DEV(N), .DATA_W(16), .CONV_CYC(10), .CLK_DIV(2), .CAPTURE_FALL(1'b0)) u0 (
    .clk(clk), .rst(rst), .start_i(start0), .cnv_o(cnv0), .sck_o(sck0), .sel_n_o(sel0),
    .sdo_i(sdo0), .res_data_o(dat0), .res_idx_o(idx0), .res_valid_o(val0), .done_o(done0));
  seq_watch #(.N(N), .DIV(2), .CONV(10), .FALL(1'b0), .IW(IW)) w0 (
    .clk(clk), .rst(rst), .words(words), .cnv(cnv0), .sck(sck0), .sel_n(sel0),
    .rdata(dat0), .ridx(idx0), .rvalid(val0), .done(done0), .sdo(sdo0));

  adc_cs_sequencer #(.N_DEV(N), .DATA_W(16), .CONV_CYC(5), .CLK_DIV(1), .CAPTURE_FALL(1'b1)) u1 (
    .clk(clk), .rst(rst), .start_i(start1), .cnv_o(cnv1), .sck_o(sck1), .sel_n_o(sel1),
    .sdo_i(sdo1), .res_data_o(dat1), .res_idx_o(idx1), .res_valid_o(val1), .done_o(done1));
  seq_watch #(.N(N), .DIV(1), .CONV(5), .FALL(1'b1), .IW(IW)) w1 (
    .clk(clk), .rst(rst), .words(words), .cnv(cnv1), .sck(sck1), .sel_n(sel1),
    .rdata(dat1), .ridx(idx1), .rvalid(val1), .done(done1), .sdo(sdo1));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==",
             checks + w0.checks + w1.checks, fails + w0.fails + w1.fails);
    $finish;
  endtask

  function automatic logic [15:0] pat(input int p, input int i);
    if (p < 16)       return 16'h1 << ((p + 5 * i) % 16);
    else if (p == 16) return 16'h0000;
    else if (p == 17) return 16'hFFFF;
    else if (p == 18) return (i % 2 == 0) ? 16'hAAAA : 16'h5555;
    else              return 16'((p * 4099 + i * 7919) & 16'hFFFF);
  endfunction

  task automatic run_both(input int p);
    for (int i = 0; i < N; i++) words[i*16 +: 16] = pat(p, i);
    start0 = 1'b1; start1 = 1'b1;
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0;
    if (p == 5) begin
      // R9: start pulses in the middle of a running sequence
      repeat (30) @(negedge clk);
      start0 = 1'b1; start1 = 1'b1;
      repeat (3) @(negedge clk);
      start0 = 1'b0; start1 = 1'b0;
    end
    while (cnv0 || cnv1) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!cnv0 && !cnv1, "R9", "no stored start after sequence", {cnv0, cnv1}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cnv0 && !cnv1, "R2", "convert low after reset", {cnv0, cnv1}, 0);
    chk(&sel0 && &sel1, "R3", "selects high after reset", {sel0, sel1}, {2*N{1'b1}});
    chk(!sck0 && !sck1, "R4", "clock low after reset", {sck0, sck1}, 0);
    chk(!val0 && !done0 && !val1 && !done1, "R8", "strobes low after reset",
        {val0, done0, val1, done1}, 0);
    for (int p = 0; p < 24; p++) run_both(p);
    // R10: start in the done clock restarts with one low convert clock
    for (int i = 0; i < N; i++) words[i*16 +: 16] = pat(20, i);
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    while (!done0) @(negedge clk);
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    chk(cnv0, "R10", "convert high one clock after done", cnv0, 1);
    while (cnv0) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1;
    report();
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end
endmodule